// File: doc/BRIEF.md
# Array Write-Protection Guard

This unit sits between the serial command front end and the array write path of a small serial memory. It keeps a boundary address, a protection flag and a one-time freeze bit. For every array write command it returns a verdict one cycle later: the write may go ahead, or it must be blocked. It also gives the 9-bit value that the front end shifts out when software reads the protection setting back.

The boundary, flag and freeze bit stand in for non-volatile cells. They are ordinary flip-flops cleared only by `por_n`, which models a full power cycle. The soft reset `rst_n` clears the arming state and the verdict outputs and leaves the stored setting as it is. An address is protected when the flag is 0 and the address is strictly greater than the boundary. When the flag is 1 nothing is protected.

Changes to the protection setting are controlled by a three-state arming machine. `ST_IDLE` moves to `ST_ARMED` on an accepted arm command (transition ARM). `ST_ARMED` goes back to `ST_IDLE` when a boundary load or a clear is carried out (transition COMMIT), and moves to `ST_FROZEN` when a freeze command is carried out (transition FREEZE). A repeated arm command in `ST_ARMED` leaves it there (transition REARM). `ST_FROZEN` is left only through `por_n`. After a soft reset the machine restarts in `ST_FROZEN` if the freeze bit is set, and in `ST_IDLE` otherwise (transition RESUME).

Top module: `wp_guard_unit`

## Requirements
- R1: After `por_n`, `prot_word` reads 9'h001 (boundary 0, flag 1), the freeze bit is clear, `permit_vld` is low, and every address is writable.
- R2: A boundary load (`cmd_psel`=1, `cmd_opc`=01, address A) that is carried out stores A as the boundary and sets the flag to 0.
- R3: A word write (`cmd_psel`=0, `cmd_opc`=01) is permitted exactly when the flag is 1 or its address is less than or equal to the boundary.
- R4: A page write (`cmd_psel`=0, `cmd_opc`=11) covers the aligned block of PAGE_WORDS (default 4) addresses that holds its address. It is permitted exactly when the flag is 1 or the highest address of that block is less than or equal to the boundary.
- R5: A write-all (`cmd_psel`=0, `cmd_opc`=00, address bits 7:6 = 01) is permitted exactly when the flag is 1.
- R6: A clear (`cmd_psel`=1, `cmd_opc`=11) with address 8'hFF that is carried out sets the boundary to 0 and the flag to 1. With any other address the command is ignored.
- R7: `prot_word` is {boundary, flag}, with the flag in bit 0 and the boundary in bits 8:1.
- R8: An arm command (`cmd_psel`=1, `cmd_opc`=00, address bits 7:6 = 11) accepted with `wen_latch` high enables exactly one following boundary load, clear or freeze. Without it, such commands are ignored.
- R9: While `wen_latch` is low, arm, boundary load, clear and freeze commands are all ignored.
- R10: A freeze (`cmd_psel`=1, `cmd_opc`=00, address 8'h00) that is carried out sets the freeze bit. From then on, boundary loads, clears and arm commands have no effect, and write verdicts continue to follow the frozen setting.
- R11: `rst_n` keeps the boundary, flag and freeze bit and drops any pending arm. Only `por_n` clears the freeze bit.
- R12: `permit_vld` pulses only for word, page and write-all commands. Any other command, and any cycle without `cmd_valid`, leaves `permit_vld` and `permit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-cycle reset, active low, synchronous; clears everything |
| rst_n | input | 1 | Soft reset, active low, synchronous; stored setting kept |
| wen_latch | input | 1 | General write-enable latch from the front end |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_psel | input | 1 | Selects protection-register commands (1) or array commands (0) |
| cmd_opc | input | 2 | Two-bit command opcode |
| cmd_addr | input | ADDR_W | Command address field |
| permit | output | 1 | Write verdict, meaningful when permit_vld is high |
| permit_vld | output | 1 | Verdict for the array write presented on the previous cycle |
| prot_word | output | ADDR_W+1 | Readback value {boundary, flag} |

## Verification
A command driven with `cmd_valid` is taken at one rising edge. The verdict on `permit`/`permit_vld` and any change to `prot_word` both appear right after that edge, so both are due one cycle after the stimulus. The verdict is computed from the setting as it stood before that same edge. The bench drives each command on a falling edge, drops `cmd_valid` on the next falling edge, and samples all outputs at that moment, half a period after the edge that produced them. An ignored command is checked through `prot_word` and through later verdicts, which would show any change it might have made.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_WORD,
        K_PAGE,
        K_ALL,
        K_PR_LOAD,
        K_PR_CLEAR,
        K_PR_ARM,
        K_PR_FREEZE
    } cmd_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FROZEN
    } arm_state_t;

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid_i,
    input  logic              psel_i,
    input  logic [1:0]        opc_i,
    input  logic [ADDR_W-1:0] addr_i,
    output cmd_kind_t         kind_o
);

    localparam logic [ADDR_W-1:0] ALL_ONES  = '1;
    localparam logic [ADDR_W-1:0] ALL_ZEROS = '0;

    logic [1:0] top2;
    assign top2 = addr_i[ADDR_W-1 -: 2];

    always_comb begin
        kind_o = K_NONE;
        if (valid_i) begin
            if (!psel_i) begin
                unique case (opc_i)
                    2'b01:   kind_o = K_WORD;
                    2'b11:   kind_o = K_PAGE;
                    2'b00:   kind_o = (top2 == 2'b01) ? K_ALL : K_NONE;
                    default: kind_o = K_NONE;
                endcase
            end else begin
                unique case (opc_i)
                    2'b01:   kind_o = K_PR_LOAD;
                    2'b11:   kind_o = (addr_i == ALL_ONES) ? K_PR_CLEAR : K_NONE;
                    2'b00: begin
                        if (top2 == 2'b11)
                            kind_o = K_PR_ARM;
                        else if (addr_i == ALL_ZEROS)
                            kind_o = K_PR_FREEZE;
                        else
                            kind_o = K_NONE;
                    end
                    default: kind_o = K_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/wp_arm_fsm.sv
module wp_arm_fsm
    import wp_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      rst_n,
    input  cmd_kind_t kind_i,
    input  logic      wen_i,
    input  logic      lock_i,
    output logic      do_load_o,
    output logic      do_clear_o,
    output logic      do_freeze_o
);

    arm_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wen_i && kind_i == K_PR_ARM)
                    state_d = ST_ARMED;                       // ARM
            end
            ST_ARMED: begin
                if (wen_i && (kind_i == K_PR_LOAD || kind_i == K_PR_CLEAR))
                    state_d = ST_IDLE;                        // COMMIT
                else if (wen_i && kind_i == K_PR_FREEZE)
                    state_d = ST_FROZEN;                      // FREEZE
                else
                    state_d = ST_ARMED;                       // REARM / hold
            end
            ST_FROZEN: state_d = ST_FROZEN;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!por_n)
            state_q <= ST_IDLE;
        else if (!rst_n)
            state_q <= lock_i ? ST_FROZEN : ST_IDLE;          // RESUME
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        do_load_o   = 1'b0;
        do_clear_o  = 1'b0;
        do_freeze_o = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                do_load_o   = wen_i && rst_n && (kind_i == K_PR_LOAD);
                do_clear_o  = wen_i && rst_n && (kind_i == K_PR_CLEAR);
                do_freeze_o = wen_i && rst_n && (kind_i == K_PR_FREEZE);
            end
            default: ;
        endcase
    end

    AST_ONE_COMMIT_PER_ARM: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (do_load_o || do_clear_o) |=> (state_q == ST_IDLE)); // R8

    AST_FROZEN_NO_COMMIT: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state_q == ST_FROZEN) |-> !(do_load_o || do_clear_o || do_freeze_o)); // R10

endmodule

// File: rtl/wp_nv_store.sv
module wp_nv_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              do_load_i,
    input  logic              do_clear_i,
    input  logic              do_freeze_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] bnd_o,
    output logic              flag_o,
    output logic              lock_o
);

    always_ff @(posedge clk) begin
        if (!por_n) begin
            bnd_o  <= '0;
            flag_o <= 1'b1;
            lock_o <= 1'b0;
        end else begin
            if (do_load_i) begin
                bnd_o  <= addr_i;
                flag_o <= 1'b0;
            end else if (do_clear_i) begin
                bnd_o  <= '0;
                flag_o <= 1'b1;
            end
            if (do_freeze_i)
                lock_o <= 1'b1;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        lock_o |=> lock_o); // R10

    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        lock_o |=> ($stable(bnd_o) && $stable(flag_o))); // R10

    AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!por_n)
        (!do_load_i && !do_clear_i) |=> ($stable(bnd_o) && $stable(flag_o))); // R8

    AST_LOAD_ACTIVATES: assert property (@(posedge clk) disable iff (!por_n)
        do_load_i |=> !flag_o); // R2

endmodule

// File: rtl/wp_judge.sv
module wp_judge
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_WORDS = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  cmd_kind_t         kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] bnd_i,
    input  logic              flag_i,
    output logic              permit_o,
    output logic              vld_o
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_WORDS - 1);

    logic [ADDR_W-1:0] page_last;
    logic              verdict;
    logic              is_write;

    assign page_last = addr_i | PAGE_MASK;

    always_comb begin
        verdict  = 1'b0;
        is_write = 1'b1;
        unique case (kind_i)
            K_WORD:  verdict = flag_i || (addr_i <= bnd_i);
            K_PAGE:  verdict = flag_i || (page_last <= bnd_i);
            K_ALL:   verdict = flag_i;
            default: is_write = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            permit_o <= 1'b0;
            vld_o    <= 1'b0;
        end else begin
            permit_o <= is_write && verdict;
            vld_o    <= is_write;
        end
    end

    AST_ALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (kind_i == K_ALL && !flag_i) |=> !permit_o); // R5

    AST_WORD_ABOVE_BLOCKED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (kind_i == K_WORD && !flag_i && addr_i > bnd_i) |=> !permit_o); // R3

    AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (kind_i == K_NONE) |=> (!vld_o && !permit_o)); // R12

endmodule

// File: rtl/wp_guard_unit.sv
module wp_guard_unit
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_WORDS = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wen_latch,
    input  logic              cmd_valid,
    input  logic              cmd_psel,
    input  logic [1:0]        cmd_opc,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              permit,
    output logic              permit_vld,
    output logic [ADDR_W:0]   prot_word
);

    cmd_kind_t         kind;
    logic              do_load, do_clear, do_freeze;
    logic [ADDR_W-1:0] bnd;
    logic              flag, lock;

    wp_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid_i (cmd_valid),
        .psel_i  (cmd_psel),
        .opc_i   (cmd_opc),
        .addr_i  (cmd_addr),
        .kind_o  (kind)
    );

    wp_arm_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .kind_i      (kind),
        .wen_i       (wen_latch),
        .lock_i      (lock),
        .do_load_o   (do_load),
        .do_clear_o  (do_clear),
        .do_freeze_o (do_freeze)
    );

    wp_nv_store #(.ADDR_W(ADDR_W)) u_nv (
        .clk         (clk),
        .por_n       (por_n),
        .do_load_i   (do_load),
        .do_clear_i  (do_clear),
        .do_freeze_i (do_freeze),
        .addr_i      (cmd_addr),
        .bnd_o       (bnd),
        .flag_o      (flag),
        .lock_o      (lock)
    );

    wp_judge #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_judge (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .kind_i   (kind),
        .addr_i   (cmd_addr),
        .bnd_i    (bnd),
        .flag_i   (flag),
        .permit_o (permit),
        .vld_o    (permit_vld)
    );

    assign prot_word = {bnd, flag};

    AST_PERMIT_NEEDS_VLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !cmd_valid |=> !permit_vld); // R12

endmodule

// File: tb/sim_wp_guard_unit.sv
`timescale 1ns/1ps
module sim_wp_guard_unit;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       wen_latch = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_psel = 1'b0;
    logic [1:0] cmd_opc = 2'b00;
    logic [7:0] cmd_addr = 8'h00;
    logic       permit, permit_vld;
    logic [8:0] prot_word;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wp_guard_unit u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wen_latch(wen_latch),
        .cmd_valid(cmd_valid), .cmd_psel(cmd_psel), .cmd_opc(cmd_opc),
        .cmd_addr(cmd_addr), .permit(permit), .permit_vld(permit_vld),
        .prot_word(prot_word)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one command for one cycle, then sample half a period after it was taken
    task automatic send(input logic psel, input logic [1:0] opc, input logic [7:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_psel = psel; cmd_opc = opc; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic verdict(input string tag, input logic [1:0] opc, input logic [7:0] addr,
                           input logic exp);
        send(1'b0, opc, addr);
        chk(tag, {7'd0, permit_vld, permit}, {7'd0, 1'b1, exp});
    endtask

    task automatic arm();      send(1'b1, 2'b00, 8'hC0); endtask
    task automatic load(input logic [7:0] a); send(1'b1, 2'b01, a); endtask
    task automatic clr(input logic [7:0] a);  send(1'b1, 2'b11, a); endtask
    task automatic freeze();   send(1'b1, 2'b00, 8'h00); endtask

    task automatic soft_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_powerup();
        @(negedge clk); @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 reset readback", prot_word, 9'h001);
        chk("R1 reset vld", {8'd0, permit_vld}, 9'd0);
        verdict("R1 R3 word FF open", 2'b01, 8'hFF, 1'b1);
        verdict("R5 write-all while clear", 2'b00, 8'h40, 1'b1);
    endtask

    task automatic t_arming();
        wen_latch = 1'b1;
        load(8'h40);
        chk("R8 load without arm ignored", prot_word, 9'h001);
        arm(); load(8'h40);
        chk("R2 R7 load stores boundary, flag 0", prot_word, 9'h080);
        load(8'h20);
        chk("R8 arm consumed", prot_word, 9'h080);
    endtask

    task automatic t_word();
        verdict("R3 word at boundary", 2'b01, 8'h40, 1'b1);
        verdict("R3 word above", 2'b01, 8'h41, 1'b0);
        verdict("R3 word zero", 2'b01, 8'h00, 1'b1);
        verdict("R3 word top", 2'b01, 8'hFF, 1'b0);
    endtask

    task automatic t_page();
        verdict("R4 page 3C fits", 2'b11, 8'h3C, 1'b1);
        verdict("R4 page 3D fits", 2'b11, 8'h3D, 1'b1);
        verdict("R4 page 40 spans", 2'b11, 8'h40, 1'b0);
        verdict("R4 page 41 above", 2'b11, 8'h41, 1'b0);
        verdict("R5 write-all while active", 2'b00, 8'h7F, 1'b0);
    endtask

    task automatic t_nonwrite();
        send(1'b0, 2'b10, 8'h10);
        chk("R12 read gives no verdict", {7'd0, permit_vld, permit}, 9'd0);
        send(1'b0, 2'b00, 8'hC0);
        chk("R12 other opc00 no verdict", {7'd0, permit_vld, permit}, 9'd0);
        send(1'b1, 2'b10, 8'h00);
        chk("R12 protect read no verdict", {7'd0, permit_vld, permit}, 9'd0);
    endtask

    task automatic t_wen();
        wen_latch = 1'b0;
        arm(); clr(8'hFF);
        chk("R9 clear ignored without wen", prot_word, 9'h080);
        wen_latch = 1'b1;
        clr(8'hFF);
        chk("R9 arm ignored without wen", prot_word, 9'h080);
    endtask

    task automatic t_clear();
        arm(); clr(8'hFE);
        chk("R6 clear wrong address ignored", prot_word, 9'h080);
        clr(8'hFF);
        chk("R6 clear", prot_word, 9'h001);
        verdict("R6 R5 write-all after clear", 2'b00, 8'h40, 1'b1);
    endtask

    task automatic t_soft();
        arm(); load(8'h10);
        chk("R2 load 10", prot_word, 9'h020);
        arm(); soft_reset();
        chk("R11 soft reset keeps setting", prot_word, 9'h020);
        load(8'h30);
        chk("R11 soft reset drops arm", prot_word, 9'h020);
    endtask

    task automatic t_lock();
        arm(); freeze();
        arm(); load(8'h70);
        chk("R10 load ignored when frozen", prot_word, 9'h020);
        arm(); clr(8'hFF);
        chk("R10 clear ignored when frozen", prot_word, 9'h020);
        verdict("R10 frozen verdict above", 2'b01, 8'h11, 1'b0);
        verdict("R10 frozen verdict at", 2'b01, 8'h10, 1'b1);
        soft_reset();
        arm(); clr(8'hFF);
        chk("R11 freeze survives soft reset", prot_word, 9'h020);
    endtask

    task automatic t_por();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk("R1 power cycle readback", prot_word, 9'h001);
        arm(); load(8'h55);
        chk("R1 R11 power cycle unfreezes", prot_word, 9'h0AA);
    endtask

    initial begin
        t_powerup();
        t_arming();
        t_word();
        t_page();
        t_nonwrite();
        t_wen();
        t_clear();
        t_soft();
        t_lock();
        t_por();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule